// File: doc/BRIEF.md
# Multi-Source Data Unit Collector

The collector gathers data units from several receive sources into one shared buffer during a bounded collection event. Each event opens when `startReq` is pulsed. The collector then raises `eventStart` for one cycle, and the sources react by lowering their `srcEmpty` lines if they hold a unit. The collector serves one source at a time by raising that source's `srcEnable`. The source presents one byte per cycle until it raises `srcEmpty` again. Each byte goes out on the buffer write port at the next free address.

The sources never write a length field, because their transfers can stop at any byte. When a source stops, the collector appends a size word of its own. The word carries an end-of-write flag in its top bit and the unit length in the lower bits. The length counts every stored byte of the unit plus the size word itself.

A source can queue another unit by lowering `srcEmpty` one cycle after it finished the previous one. The event closes with a one-cycle `eventDone` once the selection finds every source empty. The buffer has a fixed depth. Bytes that do not fit are dropped, and a sticky `overflow` bit records the loss.

Top module: `du_collector`

## Requirements
- R1: One cycle after `startReq` is seen high in the idle state, `eventStart` is high for exactly one cycle. That cycle clears `overflow` and restarts buffer addressing at 0.
- R2: At most one bit of `srcEnable` is high in any cycle. A source whose `srcEmpty` stays high (an unused source) is never enabled.
- R3: A byte on the enabled source's lane is written while its `srcEmpty` is low, one write per cycle. The writes go in presentation order to consecutive addresses.
- R4: After a source raises `srcEmpty`, the next write is its size word: bit 7 set as the end-of-write flag, and bits 6:0 equal to the number of unit bytes stored plus one.
- R5: The first unit of an event comes from the lowest-indexed non-empty source. After each size word, the next unit comes from the next non-empty index after the current one, wrapping around. This order includes the same source when it lowered `srcEmpty` again one cycle after finishing.
- R6: When the selection finds no non-empty source, `eventDone` is high for exactly one cycle. No write occurs after that until the next event starts.
- R7: Only addresses below the buffer depth are written. Any byte or size word that finds the buffer full is dropped and sets `overflow`, which stays set until the next `eventStart`. A stream that exactly fills the buffer does not set it.
- R8: While reset is applied, all enables, the write strobe, `eventStart`, `eventDone` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to open a collection event |
| srcData | input | NUM_SRC*DATA_W | Byte lane per source, source i at bits i*DATA_W upward |
| srcEmpty | input | NUM_SRC | High when the source has nothing to send; tie high if unused |
| srcEnable | output | NUM_SRC | Grant to the source being served |
| wrEn | output | 1 | Buffer write strobe |
| wrAddr | output | $clog2(DEPTH) | Buffer write address |
| wrData | output | DATA_W | Buffer write data |
| eventStart | output | 1 | One-cycle event-open pulse |
| eventDone | output | 1 | One-cycle event-close pulse |
| overflow | output | 1 | Sticky flag: data was dropped because the buffer was full |

## Verification
Two functions meet in the cycle after a source raises `srcEmpty`: the size word of the finished unit is issued, and the next source is chosen. In that same cycle a source may lower `srcEmpty` again to offer another unit. The bench provokes this with stimulus vectors that give one source several units, both alone and mixed with other sources. It judges the result from the full buffer image, which must show each size word directly after its unit and the units in wrap-around order. A second meeting point lies at the buffer edge, where the last free slot can take either a data byte or a size word. An exact-fit stream and an over-full stream check the buffer image, the write count and `overflow`.

// File: rtl/collector_pkg.sv
package collector_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SCAN,
    ST_XFER,
    ST_SIZE,
    ST_DONE
  } colState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clear;     // new event: restart addressing, clear overflow
    logic takeData;  // store the byte on the served lane
    logic takeSize;  // store the trailing size word
  } colStrobe_t;

endpackage

// File: rtl/collector_ctrl.sv
module collector_ctrl
  import collector_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startReq,
  input  logic [NUM_SRC-1:0] srcEmpty,
  output logic [NUM_SRC-1:0] srcEnable,
  output logic [IDX_W-1:0]   cur,
  output colStrobe_t         strobe,
  output logic               eventStart,
  output logic               eventDone
);

  colState_t  state, stateNext;
  logic [IDX_W-1:0] curNext, scanBase, pick;
  logic found;

  // Search for the first non-empty source at or after scanBase, wrapping
  always_comb begin
    int idx;
    if (state == ST_SIZE)
      scanBase = (cur == IDX_W'(NUM_SRC - 1)) ? '0 : cur + 1'b1;
    else
      scanBase = '0;
    found = 1'b0;
    pick  = '0;
    for (int off = 0; off < NUM_SRC; off++) begin
      idx = int'(scanBase) + off;
      if (idx >= NUM_SRC) idx = idx - NUM_SRC;
      if (!found && !srcEmpty[IDX_W'(idx)]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    stateNext = state;
    curNext   = cur;
    strobe    = '0;
    unique case (state)
      ST_IDLE:  if (startReq) stateNext = ST_START;
      ST_START: begin
        strobe.clear = 1'b1;
        stateNext    = ST_SCAN;
      end
      ST_SCAN: begin
        if (found) begin
          curNext   = pick;
          stateNext = ST_XFER;
        end else begin
          stateNext = ST_DONE;
        end
      end
      ST_XFER: begin
        if (!srcEmpty[cur]) strobe.takeData = 1'b1;
        else                stateNext       = ST_SIZE;
      end
      ST_SIZE: begin
        strobe.takeSize = 1'b1;
        if (found) begin
          curNext   = pick;
          stateNext = ST_XFER;
        end else begin
          stateNext = ST_DONE;
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
    end else begin
      state <= stateNext;
      cur   <= curNext;
    end
  end

  assign eventStart = (state == ST_START);
  assign eventDone  = (state == ST_DONE);

  // One grant line per source; only the served one, and only while streaming
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_enable
    assign srcEnable[g] = (state == ST_XFER) && (cur == IDX_W'(g));
  end

endmodule

// File: rtl/collector_dp.sv
module collector_dp
  import collector_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 32,
  parameter int ADDR_W  = 5,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  colStrobe_t                strobe,
  input  logic [IDX_W-1:0]          cur,
  input  logic [NUM_SRC*DATA_W-1:0] srcData,
  output logic                      wrEn,
  output logic [ADDR_W-1:0]         wrAddr,
  output logic [DATA_W-1:0]         wrData,
  output logic                      overflow
);

  localparam int FILL_W = ADDR_W + 1;
  localparam int SZ_W   = DATA_W - 1;

  logic [FILL_W-1:0] fill;      // next free address, reaches DEPTH when full
  logic [FILL_W-1:0] unitCnt;   // bytes stored for the unit in progress
  logic [DATA_W-1:0] selByte, sizeWord;
  logic full;

  assign full     = (fill == FILL_W'(DEPTH));
  assign sizeWord = {1'b1, SZ_W'(unitCnt + 1'b1)};

  always_comb begin
    selByte = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (cur == IDX_W'(i)) selByte = srcData[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill     <= '0;
      unitCnt  <= '0;
      overflow <= 1'b0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrEn <= 1'b0;
      if (strobe.clear) begin
        fill     <= '0;
        unitCnt  <= '0;
        overflow <= 1'b0;
      end else if (strobe.takeData || strobe.takeSize) begin
        if (full) begin
          overflow <= 1'b1;
        end else begin
          wrEn   <= 1'b1;
          wrAddr <= fill[ADDR_W-1:0];
          wrData <= strobe.takeSize ? sizeWord : selByte;
          fill   <= fill + 1'b1;
        end
        if (strobe.takeSize)      unitCnt <= '0;
        else if (!full)           unitCnt <= unitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/du_collector.sv
module du_collector
  import collector_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 32   // must stay below 2**(DATA_W-1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        startReq,
  input  logic [NUM_SRC*DATA_W-1:0]   srcData,
  input  logic [NUM_SRC-1:0]          srcEmpty,
  output logic [NUM_SRC-1:0]          srcEnable,
  output logic                        wrEn,
  output logic [$clog2(DEPTH)-1:0]    wrAddr,
  output logic [DATA_W-1:0]           wrData,
  output logic                        eventStart,
  output logic                        eventDone,
  output logic                        overflow
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  colStrobe_t       strobe;
  logic [IDX_W-1:0] cur;

  collector_ctrl #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startReq   (startReq),
    .srcEmpty   (srcEmpty),
    .srcEnable  (srcEnable),
    .cur        (cur),
    .strobe     (strobe),
    .eventStart (eventStart),
    .eventDone  (eventDone)
  );

  collector_dp #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .cur      (cur),
    .srcData  (srcData),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .overflow (overflow)
  );

endmodule

// File: rtl/collector_checker.sv
module collector_checker #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] srcEnable,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic               eventStart,
  input logic               eventDone,
  input logic               overflow
);

  assert_one_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(srcEnable));

  assert_quiet_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eventStart || eventDone) |-> (srcEnable == '0));

  assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eventStart |=> !eventStart);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && $past(wrEn)) |-> (wrAddr == $past(wrAddr) + 1'b1));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eventDone |=> !eventDone);

  assert_no_write_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eventDone |=> !wrEn);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overflow) |-> $past(eventStart));

endmodule

bind du_collector collector_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srcEnable  (srcEnable),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .eventStart (eventStart),
  .eventDone  (eventDone),
  .overflow   (overflow)
);

// File: tb/tb_du_collector.sv
`timescale 1ns/1ps
module tb_du_collector;

  localparam int NS    = 4;
  localparam int DEPTH = 32;
  localparam int NV    = 7;
  // per vector: nibble s = unit length of source s (0 = unused), 2-bit field s = unit count
  localparam logic [15:0] VEC_LEN [NV] = '{16'h0003, 16'h2043, 16'h0500, 16'h0403,
                                          16'h0000, 16'h6336, 16'h1000};
  localparam logic [7:0]  VEC_BLK [NV] = '{8'h01, 8'h45, 8'h30, 8'h12, 8'h00, 8'h55, 8'h80};

  logic clk = 0, rst_n = 0, startReq = 0;
  logic [NS*8-1:0] srcData;
  logic [NS-1:0]   srcEmpty = '1;
  logic [NS-1:0]   srcEnable;
  logic wrEn, eventStart, eventDone, overflow;
  logic [4:0] wrAddr;
  logic [7:0] wrData;

  du_collector dut (.clk(clk), .rst_n(rst_n), .startReq(startReq), .srcData(srcData),
    .srcEmpty(srcEmpty), .srcEnable(srcEnable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .eventStart(eventStart), .eventDone(eventDone), .overflow(overflow));

  always #4 clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 0;
  int cfgLen [NS], cfgBlk [NS], k [NS], blk [NS];
  logic [7:0] mem [DEPTH], expMem [DEPTH];
  int wrCount, startCount, doneCount, multiHits, unusedHits, wrAfterDone, expWrites, expTotal;
  bit inDone;

  function automatic logic [7:0] byteVal(int s, int b, int kk, int len);
    logic [7:0] v;
    if (kk == 0)      v = 8'(s);
    else if (kk == 1) v = 8'h40 | 8'(b);
    else begin
      v = 8'((s * 16 + b * 4 + kk) & 127);
      if (kk == len - 1) v = v | 8'h80;
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always_comb
    for (int s = 0; s < NS; s++) srcData[s*8 +: 8] = byteVal(s, blk[s], k[s], cfgLen[s]);

  // Source models: decide mid-cycle, change just after the next rising edge
  initial begin
    for (int s = 0; s < NS; s++) begin k[s] = 0; blk[s] = 0; cfgLen[s] = 0; cfgBlk[s] = 0; end
    forever begin
      int nk [NS], nb [NS];
      logic [NS-1:0] ne;
      @(negedge clk);
      ne = srcEmpty;
      for (int s = 0; s < NS; s++) begin
        nk[s] = k[s]; nb[s] = blk[s];
        if (eventStart && cfgLen[s] != 0 && cfgBlk[s] != 0) begin
          ne[s] = 1'b0; nk[s] = 0; nb[s] = 0;
        end else if (srcEnable[s] && !srcEmpty[s]) begin
          nk[s] = k[s] + 1;
          if (k[s] + 1 == cfgLen[s]) begin ne[s] = 1'b1; nb[s] = blk[s] + 1; end
        end else if (srcEnable[s] && srcEmpty[s] && blk[s] < cfgBlk[s]) begin
          ne[s] = 1'b0; nk[s] = 0;   // next unit, one clock after finishing
        end
      end
      @(posedge clk); #1;
      srcEmpty = ne;
      for (int s = 0; s < NS; s++) begin k[s] = nk[s]; blk[s] = nb[s]; end
    end
  end

  // Output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (wrEn) begin
          mem[wrAddr] = wrData;
          wrCount++;
          if (inDone) wrAfterDone++;
        end
        if ($countones(srcEnable) > 1) multiHits++;
        for (int s = 0; s < NS; s++) if (srcEnable[s] && cfgLen[s] == 0) unusedHits++;
        if (eventStart) startCount++;
        if (eventDone) begin doneCount++; inDone = 1; end
      end
    end
  end

  task automatic push(logic [7:0] v);
    if (expTotal < DEPTH) expMem[expTotal] = v;
    expTotal++;
  endtask

  task automatic buildExpected();
    int rem [NS], bi [NS];
    int s, cnt;
    expTotal = 0;
    for (int i = 0; i < NS; i++) begin rem[i] = (cfgLen[i] != 0) ? cfgBlk[i] : 0; bi[i] = 0; end
    s = -1;
    for (int i = 0; i < NS; i++) if (s < 0 && rem[i] > 0) s = i;
    while (s >= 0) begin
      for (int j = 0; j < cfgLen[s]; j++) push(byteVal(s, bi[s], j, cfgLen[s]));
      push(8'h80 | 8'(cfgLen[s] + 1));
      bi[s]++; rem[s]--;
      cnt = s; s = -1;
      for (int off = 1; off <= NS; off++)
        if (s < 0 && rem[(cnt + off) % NS] > 0) s = (cnt + off) % NS;
    end
    expWrites = (expTotal < DEPTH) ? expTotal : DEPTH;
  endtask

  task automatic runEvent(logic [15:0] lw, logic [7:0] bw, string tag);
    int bad, waitCnt;
    for (int s = 0; s < NS; s++) begin
      cfgLen[s] = int'(lw[s*4 +: 4]);
      cfgBlk[s] = int'(bw[s*2 +: 2]);
    end
    buildExpected();
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    @(negedge clk);
    wrCount = 0; startCount = 0; doneCount = 0; multiHits = 0; unusedHits = 0;
    wrAfterDone = 0; inDone = 0;
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    waitCnt = 0;
    while (doneCount == 0 && waitCnt < 3000) begin @(posedge clk); waitCnt++; end
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    $display("event %s", tag);
    check(startCount == 1, "R1", "eventStart cycles", startCount, 1);
    check(doneCount == 1, "R6", "eventDone cycles", doneCount, 1);
    check(wrAfterDone == 0, "R6", "writes after done", wrAfterDone, 0);
    check(wrCount == expWrites, "R3", "write count", wrCount, expWrites);
    bad = -1;
    for (int i = 0; i < expWrites; i++) if (bad < 0 && mem[i] !== expMem[i]) bad = i;
    if (bad >= 0)
      check(0, "R3 R4 R5", $sformatf("buffer byte %0d", bad), int'(mem[bad]), int'(expMem[bad]));
    else
      check(1, "R3 R4 R5", "buffer image", 0, 0);
    if (expWrites > 0 && expTotal <= DEPTH)
      check(mem[expWrites-1] === expMem[expWrites-1], "R4", "final size word",
            int'(mem[expWrites-1]), int'(expMem[expWrites-1]));
    check(overflow == (expTotal > DEPTH), "R7", "overflow flag", int'(overflow),
          int'(expTotal > DEPTH));
    check(multiHits == 0, "R2", "cycles with several enables", multiHits, 0);
    check(unusedHits == 0, "R2", "enables of unused sources", unusedHits, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs while reset is held
    check(srcEnable == '0, "R8", "srcEnable in reset", int'(srcEnable), 0);
    check(wrEn == 0, "R8", "wrEn in reset", int'(wrEn), 0);
    check(eventStart == 0 && eventDone == 0, "R8", "event pulses in reset",
          int'({eventStart, eventDone}), 0);
    check(overflow == 0, "R8", "overflow in reset", int'(overflow), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) runEvent(VEC_LEN[v], VEC_BLK[v], $sformatf("vector %0d", v));

    // R7 boundary: stream fills the buffer exactly (4 x 8 bytes)
    runEvent(16'h7777, 8'h55, "exact fit");
    // R7: stream of 64 bytes into 32 slots
    runEvent(16'hFFFF, 8'h55, "overflow");
    // R1 / R7: next event restarts at address 0 and clears overflow
    runEvent(16'h2043, 8'h45, "after overflow");

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule